// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is the slave side of a two-wire serial bus with a byte memory behind it. It watches the bus clock (SCL) and data (SDA) lines and finds start and stop conditions. It then receives a first byte that carries two device-select bits, five upper memory address bits and a read/write flag. It acknowledges only when the device-select bits agree with its two strap inputs, so four such slaves can share one bus. A write sends one further byte of low address and one data byte. The byte is committed when the master sends a stop, and a programmable busy period then follows in which the slave ignores the bus. A read returns bytes from an internal address pointer, most significant bit first, and continues for as long as the master acknowledges.

SCL and SDA are oversampled in the system clock domain through a synchronizer. SDA is driven only through an open-drain style enable: `sda_oe` high pulls the line low. A controller enumeration walks the bus protocol. IDLE waits for a start. DEV shifts in the slave address. DEV_ACK acknowledges it and branches to WADR on a write or RD_BIT on a read. WADR shifts in the low address byte and WADR_ACK acknowledges it. WDAT shifts in the data byte and WDAT_ACK acknowledges it. WAIT_STOP holds until the stop that commits the write. RD_BIT drives out the eight data bits. RD_MACK samples the master's acknowledge and branches back to RD_BIT or to IDLE. A start (while not busy) moves any state to DEV. A stop moves any state to IDLE, and it commits the write only from WAIT_STOP. While busy, the controller is held in IDLE.

Top module: `twsm_slave`

## Requirements
- R1: After reset `sda_oe` is low, so SDA is released, and the controller waits in IDLE for a start.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Outside the busy period, a start in any state, including partway through a byte, restarts slave-address reception.
- R3: The slave address is the first byte after a start and is received MSB first. Bit 7 must equal the inverse of `strap_s2` and bit 6 must equal `strap_s1`. On a match the block pulls SDA low for the ninth clock.
- R4: On a device-select mismatch the block gives no acknowledge and ignores the bus until the next start.
- R5: Bits 5 to 1 of the slave address are address bits 12 to 8, and bit 0 is the read flag (1 = read, 0 = write). A write acknowledges the following low address byte and the single data byte that follows it.
- R6: The data byte is written to memory only by a stop after its acknowledge. A stop or start before then leaves memory unchanged and starts no busy period.
- R7: For WR_CYCLES clocks after a committing stop, the block ignores starts and all other bus activity and returns no acknowledge.
- R8: A read drives the byte at the address pointer MSB first. SDA changes only while SCL is low, except when a start or stop releases it.
- R9: The low address byte of a write loads the pointer with the 13-bit address. The pointer increments modulo 8192 after every byte read and after every committed write. A repeated start followed by a read therefore returns the addressed byte.
- R10: When the master does not acknowledge a read byte, the block releases SDA and idles until the next start.
- R11: Storage holds 2^STORE_AW bytes, indexed by the low STORE_AW bits of the 13-bit address. The default is 9; a value of 13 gives the full 8192-byte array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_s1 | input | 1 | Device-select strap, matched directly |
| strap_s2 | input | 1 | Device-select strap, matched inverted |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
Assertions check the following on every clock:
- SDA is never pulled during the busy period.
- A start moves the controller to address reception.
- A mismatched slave address leads to IDLE with SDA released.
- The pointer steps by one, wrapping at 8192, at the end of each read byte.
- The SDA enable changes only while SCL is low, or when a start or stop releases it.
- A busy period begins only after a committing stop.

Only the bench's scenarios can show the following:
- Data really reaches the array and comes back through repeated-start and current-pointer reads.
- Aborted and stop-terminated writes leave memory untouched.
- The read crosses the top of the address space.
- A device held busy refuses a fresh address byte.

// File: rtl/twsm_pkg.sv
package twsm_pkg;

    localparam int ADDR_W = 13;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADR,
        ST_WADR_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_WAIT_STOP,
        ST_RD_BIT,
        ST_RD_MACK
    } twsm_state_e;

endpackage

// File: rtl/twsm_bus_cond.sv
module twsm_bus_cond #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int N = (SYNC_N < 2) ? 2 : SYNC_N;

    logic [N-1:0] scl_q;
    logic [N-1:0] sda_q;
    logic         scl_p;
    logic         sda_p;

    // Bus idles high; reset all stages to the released level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[N-2:0], scl_i};
            sda_q <= {sda_q[N-2:0], sda_i};
            scl_p <= scl_q[N-1];
            sda_p <= sda_q[N-1];
        end
    end

    assign scl_s     = scl_q[N-1];
    assign sda_s     = sda_q[N-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/twsm_busy.sv
module twsm_busy #(
    parameter int CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic busy_o
);

    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (go_i) begin
            cnt <= CW'(CYC);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy_o = (cnt != '0);

    // R6
    busy_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(go_i));

endmodule

// File: rtl/twsm_mem.sv
module twsm_mem #(
    parameter int STORE_AW = 9,
    parameter int ADDR_W   = 13,
    parameter int BYTE_W   = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);

    localparam int DEPTH = 1 << STORE_AW;

    logic [BYTE_W-1:0] arr [DEPTH];

    // R11: only the low address bits index the storage.
    always_ff @(posedge clk) begin
        if (we) begin
            arr[addr[STORE_AW-1:0]] <= wdata;
        end
    end

    assign rdata = arr[addr[STORE_AW-1:0]];

endmodule

// File: rtl/twsm_slave.sv
module twsm_slave
    import twsm_pkg::*;
#(
    parameter int WR_CYCLES = 1000,
    parameter int STORE_AW  = 9,
    parameter int SYNC_N    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic strap_s1,
    input  logic strap_s2,
    output logic sda_oe
);

    localparam int HI_W = ADDR_W - BYTE_W;

    twsm_state_e       state;
    twsm_state_e       nxt;
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] tx;
    logic [BYTE_W-1:0] wbyte;
    logic [BYTE_W-1:0] mem_rd;
    logic [ADDR_W-1:0] ptr;
    logic [HI_W-1:0]   hi;
    logic              rw;
    logic              mack;
    logic              busy;
    logic              go;
    logic              byte_done;
    logic              addr_match;

    twsm_bus_cond #(.SYNC_N(SYNC_N)) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twsm_busy #(.CYC(WR_CYCLES)) u_busy (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (go),
        .busy_o (busy)
    );

    twsm_mem #(.STORE_AW(STORE_AW), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_mem (
        .clk   (clk),
        .we    (go),
        .addr  (ptr),
        .wdata (wbyte),
        .rdata (mem_rd)
    );

    assign byte_done  = scl_fall && (bit_cnt == 4'd8);
    assign addr_match = (sh[7] == ~strap_s2) && (sh[6] == strap_s1);
    assign go         = stop_det && !busy && (state == ST_WAIT_STOP);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        if (busy) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_DEV;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_DEV:       if (byte_done) nxt = addr_match ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:   if (scl_fall) nxt = rw ? ST_RD_BIT : ST_WADR;
                ST_WADR:      if (byte_done) nxt = ST_WADR_ACK;
                ST_WADR_ACK:  if (scl_fall) nxt = ST_WDAT;
                ST_WDAT:      if (byte_done) nxt = ST_WDAT_ACK;
                ST_WDAT_ACK:  if (scl_fall) nxt = ST_WAIT_STOP;
                ST_WAIT_STOP: nxt = ST_WAIT_STOP;
                ST_RD_BIT:    if (scl_fall && bit_cnt == 4'd7) nxt = ST_RD_MACK;
                ST_RD_MACK:   if (scl_fall) nxt = mack ? ST_RD_BIT : ST_IDLE;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // Datapath: shifters, counters, pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            sh      <= '0;
            tx      <= '0;
            wbyte   <= '0;
            ptr     <= '0;
            hi      <= '0;
            rw      <= 1'b0;
            mack    <= 1'b0;
        end else if (go) begin
            ptr <= ptr + 1'b1;
        end else if (!busy && start_det) begin
            bit_cnt <= '0;
        end else if (!busy && !stop_det) begin
            unique case (state)
                ST_DEV, ST_WADR, ST_WDAT: begin
                    if (scl_rise) begin
                        sh      <= {sh[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (byte_done) begin
                        if (state == ST_DEV) begin
                            hi <= sh[5:1];
                            rw <= sh[0];
                        end else if (state == ST_WADR) begin
                            ptr <= {hi, sh};
                        end else begin
                            wbyte <= sh;
                        end
                    end
                end
                ST_DEV_ACK, ST_WADR_ACK, ST_WDAT_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (state == ST_DEV_ACK && rw) begin
                            tx <= mem_rd;
                        end
                    end
                end
                ST_RD_BIT: begin
                    if (scl_fall) begin
                        if (bit_cnt == 4'd7) begin
                            ptr <= ptr + 1'b1;
                        end else begin
                            tx      <= {tx[BYTE_W-2:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_RD_MACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_s;
                    end
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (mack) begin
                            tx <= mem_rd;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state)
            ST_DEV_ACK, ST_WADR_ACK, ST_WDAT_ACK: sda_oe = 1'b1;
            ST_RD_BIT:                            sda_oe = ~tx[BYTE_W-1];
            default:                              sda_oe = 1'b0;
        endcase
    end

    // R7
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    // R2
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !busy) |=> (state == ST_DEV));

    // R4
    mismatch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV && byte_done && !addr_match && !busy)
        |=> (state == ST_IDLE && !sda_oe));

    // R9
    rd_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_BIT && scl_fall && bit_cnt == 4'd7 && !busy)
        |=> (ptr == $past(ptr) + 13'd1));

    // R8
    scl_low_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> (!scl_s || $past(start_det) || $past(stop_det)));

endmodule

// File: tb/twsm_slave_tb.sv
module twsm_slave_tb;

    localparam int Q   = 8;
    localparam int WRC = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic s1 = 1'b1;
    logic s2 = 1'b0;
    logic dut_oe;
    logic sda_bus;
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;

    assign sda_bus = ~(m_low | dut_oe);

    always #10 clk = ~clk;

    twsm_slave #(.WR_CYCLES(WRC), .STORE_AW(9), .SYNC_N(2)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (m_scl),
        .sda_i    (sda_bus),
        .strap_s1 (s1),
        .strap_s2 (s2),
        .sda_oe   (dut_oe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic quarter();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; quarter();
        m_scl = 1'b1; quarter();
        m_low = 1'b1; quarter();
        m_scl = 1'b0; quarter();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; quarter();
        m_scl = 1'b1; quarter();
        m_low = 1'b0; quarter();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_low = ~b[i]; quarter();
            m_scl = 1'b1;  quarter(); quarter();
            m_scl = 1'b0;  quarter();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        m_low = 1'b0; quarter();
        m_scl = 1'b1; quarter();
        ack = ~sda_bus; quarter();
        m_scl = 1'b0; quarter();
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit mack);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            quarter();
            m_scl = 1'b1; quarter();
            b[i] = sda_bus; quarter();
            m_scl = 1'b0;
        end
        m_low = mack; quarter();
        m_scl = 1'b1; quarter(); quarter();
        m_scl = 1'b0; quarter();
        m_low = 1'b0;
    endtask

    // Slave address: bit7 = ~strap_s2, bit6 = strap_s1, bits5:1 = A12..A8, bit0 = read
    function automatic logic [7:0] dev(input logic [4:0] hi, input bit rd);
        return {~s2, s1, hi, rd};
    endfunction

    task automatic write_mem(input logic [12:0] a, input logic [7:0] d,
                             output bit a0, output bit a1, output bit a2);
        bus_start();
        send_byte(dev(a[12:8], 1'b0), a0);
        send_byte(a[7:0], a1);
        send_byte(d, a2);
        bus_stop();
    endtask

    task automatic wait_busy();
        repeat (WRC + 200) @(negedge clk);
    endtask

    task automatic read_at(input logic [12:0] a, output logic [7:0] d);
        bit k;
        bus_start();
        send_byte(dev(a[12:8], 1'b0), k);
        send_byte(a[7:0], k);
        bus_start();
        send_byte(dev(5'd0, 1'b1), k);
        recv_byte(d, 1'b0);
        bus_stop();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(dut_oe == 1'b0 && sda_bus == 1'b1, "R1 released after reset", dut_oe, 0);
    endtask

    task automatic t_write_basic();
        bit a0, a1, a2;
        write_mem(13'h1235, 8'h88, a0, a1, a2);
        chk(a0, "R3 slave address ack", a0, 1);
        chk(a1, "R5 low address ack", a1, 1);
        chk(a2, "R5 data byte ack", a2, 1);
        wait_busy();
    endtask

    task automatic t_busy();
        bit a0, a1, a2, k;
        write_mem(13'h1234, 8'h77, a0, a1, a2);
        bus_start();
        send_byte(dev(5'd0, 1'b0), k);
        chk(!k, "R7 no ack while busy", k, 0);
        bus_stop();
        wait_busy();
    endtask

    task automatic t_incr();
        logic [7:0] d;
        bit k;
        bus_start();
        send_byte(dev(5'd0, 1'b1), k);
        recv_byte(d, 1'b0);
        bus_stop();
        chk(d == 8'h88, "R9 pointer after write", d, 8'h88);
    endtask

    task automatic t_random();
        logic [7:0] d;
        read_at(13'h1234, d);
        chk(d == 8'h77, "R9 repeated start read", d, 8'h77);
        read_at(13'h1034, d);
        chk(d == 8'h77, "R11 storage aliasing", d, 8'h77);
    endtask

    task automatic t_mismatch();
        bit k;
        bus_start();
        send_byte({s2, s1, 5'd0, 1'b0}, k);
        chk(!k, "R4 strap_s2 mismatch", k, 0);
        bus_stop();
        bus_start();
        send_byte({~s2, ~s1, 5'd0, 1'b0}, k);
        chk(!k, "R3 strap_s1 mismatch", k, 0);
        bus_stop();
        bus_start();
        send_byte(dev(5'd0, 1'b0), k);
        chk(k, "R4 recovers at next start", k, 1);
        bus_stop();
    endtask

    task automatic t_abort();
        bit a0, a1, a2, k;
        logic [7:0] d;
        write_mem(13'h0100, 8'h11, a0, a1, a2);
        wait_busy();
        bus_start();
        send_byte(dev(5'h01, 1'b0), k);
        send_byte(8'h00, k);
        send_bits(8'hEE, 4);
        bus_start();
        send_byte(dev(5'd0, 1'b1), k);
        chk(k, "R2 start mid-byte restarts", k, 1);
        recv_byte(d, 1'b0);
        bus_stop();
        chk(d == 8'h11, "R6 aborted write discarded", d, 8'h11);
        bus_start();
        send_byte(dev(5'h01, 1'b0), k);
        send_byte(8'h00, k);
        bus_stop();
        bus_start();
        send_byte(dev(5'd0, 1'b0), k);
        chk(k, "R6 early stop starts no busy", k, 1);
        bus_stop();
        read_at(13'h0100, d);
        chk(d == 8'h11, "R6 early stop no write", d, 8'h11);
    endtask

    task automatic t_wrap();
        bit a0, a1, a2, k;
        logic [7:0] d0, d1, d2;
        write_mem(13'h1FFF, 8'h5A, a0, a1, a2);
        wait_busy();
        write_mem(13'h0000, 8'hC3, a0, a1, a2);
        wait_busy();
        bus_start();
        send_byte(dev(5'h1F, 1'b0), k);
        send_byte(8'hFF, k);
        bus_start();
        send_byte(dev(5'd0, 1'b1), k);
        recv_byte(d0, 1'b1);
        recv_byte(d1, 1'b0);
        chk(d0 == 8'h5A, "R8 read top byte", d0, 8'h5A);
        chk(d1 == 8'hC3, "R9 pointer wraps to zero", d1, 8'hC3);
        recv_byte(d2, 1'b0);
        chk(d2 == 8'hFF && dut_oe == 1'b0, "R10 released after nack", d2, 8'hFF);
        bus_stop();
    endtask

    initial begin
        t_reset();
        t_write_basic();
        t_busy();
        t_incr();
        t_random();
        t_mismatch();
        t_abort();
        t_wrap();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule